// File: doc/BRIEF.md
# Cascaded Interrupt Status Encoder

This block merges three groups of interrupt requests into a single packed status word that a processor reads to find out which source to service. The critical group has four sources and no mask. The main group has seventeen sources and the peripheral group has thirty-two. Each of the latter two has its own mask register, and in each register a set bit blocks the corresponding source. In every group the block picks the unmasked active source with the smallest index. It reports that index together with a present flag, and it drives one combined interrupt line.

Some slots are fixed cascade points rather than pins. Slot 2 of the critical group and slot 4 of the main group both carry the peripheral group's present flag. Slot 0 of the peripheral group carries the single pending line of the DMA sub-controller. Software reads the word and inspects the groups starting with critical, then main, then peripheral. When it lands on a cascade slot it follows that slot down into the lower group.

The status word and the combined line are both registered. A change on any input or mask shows up one clock after the edge at which it is sampled.

Top module: `irq_cascade_encoder`

## Requirements
- R1: After reset every bit of both mask registers is set, `status_o` is all zeros and `irq_o` is 0.
- R2: A write with `wr_en_i`=1 loads the main mask from `wr_data_i[16:0]` when `wr_sel_i`=0, or the peripheral mask from `wr_data_i[31:0]` when `wr_sel_i`=1. Main source n is masked by data bit (16−n) and peripheral source n by data bit (31−n), with 1 meaning masked. Mask registers hold their value when no write occurs.
- R3: Critical group: among active sources the lowest index wins. The result appears as present in `status_o[10]` and as the index in `status_o[9:8]`.
- R4: Main group: the lowest active unmasked index appears as present in `status_o[21]` and as the index in `status_o[20:16]`.
- R5: Peripheral group: the lowest active unmasked index appears as present in `status_o[29]` and as the index in `status_o[28:24]`.
- R6: Critical slot 2 and main slot 4 are driven by the peripheral present flag. The external inputs `crit_src_i[2]` and `main_src_i[4]` have no effect.
- R7: Peripheral slot 0 is driven by `dma_pend_i`, and `per_src_i[0]` has no effect.
- R8: All bits of `status_o` outside the three present flags and index fields are 0, and the index field of a group with no winner is 0.
- R9: `irq_o` is the OR of the three present flags. Both `irq_o` and `status_o` reflect the inputs and masks sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crit_src_i | input | 4 | Critical request lines (bit 2 unused) |
| main_src_i | input | 17 | Main request lines (bit 4 unused) |
| per_src_i | input | 32 | Peripheral request lines (bit 0 unused) |
| dma_pend_i | input | 1 | Summary pending line of the DMA sub-controller |
| wr_en_i | input | 1 | Mask write strobe |
| wr_sel_i | input | 1 | Mask select: 0 main, 1 peripheral |
| wr_data_i | input | 32 | Mask write data |
| status_o | output | 32 | Packed encoded status word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A mask bit stored under the wrong source, or bit order that is not reversed, shows up in the status word one clock after the write edge. It appears either as a group that goes missing or as a different winning index. A broken cascade shows up in the same cycle as the peripheral request, as a wrong critical or main field. A stale or leaked index shows up at once as nonzero bits next to a cleared present flag. The bench runs its own model of the whole word every cycle, so any of these faults is caught within one clock of the stimulus that exposes it.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int STAT_W        = 32;
  localparam int CRIT_PRES_BIT = 10;
  localparam int CRIT_IDX_LSB  = 8;
  localparam int MAIN_PRES_BIT = 21;
  localparam int MAIN_IDX_LSB  = 16;
  localparam int PER_PRES_BIT  = 29;
  localparam int PER_IDX_LSB   = 24;

  // index of the lowest set bit among the first n bits, or n if none
  function automatic int lowest_set(input logic [31:0] v, input int n);
    int r;
    r = n;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // true when no bit below position idx is set
  function automatic logic none_below(input logic [31:0] v, input int idx);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < idx && v[i]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int MAIN_N = 17,
  parameter int PER_N  = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [MAIN_N-1:0] main_mask_o,
  output logic [PER_N-1:0]  per_mask_o
);
  logic wr_main, wr_per;
  assign wr_main = wr_en_i && !wr_sel_i;
  assign wr_per  = wr_en_i &&  wr_sel_i;

  // data bit order is reversed: source n sits at bit (N-1-n)
  for (genvar n = 0; n < MAIN_N; n++) begin : g_main
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       main_mask_o[n] <= 1'b1;
      else if (wr_main) main_mask_o[n] <= wr_data_i[MAIN_N-1-n];
    end
  end

  for (genvar n = 0; n < PER_N; n++) begin : g_per
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      per_mask_o[n] <= 1'b1;
      else if (wr_per) per_mask_o[n] <= wr_data_i[PER_N-1-n];
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(main_mask_o) && $stable(per_mask_o))); // R2
  AST_MAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main |=> (main_mask_o[0] == $past(wr_data_i[MAIN_N-1]))); // R2
endmodule

// File: rtl/irq_group_enc.sv
module irq_group_enc
  import irq_enc_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  mask_i,
  output logic          present_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0]  active_w;
  logic [31:0]   active_ext;
  int            win;

  assign active_w   = req_i & ~mask_i;
  assign active_ext = 32'(active_w);

  always_comb begin
    win       = lowest_set(active_ext, N);
    present_o = (win < N);
    idx_o     = present_o ? IW'(win) : '0;
  end

  AST_GRP_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    present_o |-> active_ext[idx_o]); // R3
  AST_GRP_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    present_o |-> none_below(active_ext, int'(idx_o))); // R4
  AST_GRP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w == '0) |-> (!present_o && idx_o == '0)); // R8
endmodule

// File: rtl/irq_cascade_encoder.sv
module irq_cascade_encoder
  import irq_enc_pkg::*;
#(
  parameter int CRIT_N    = 4,
  parameter int MAIN_N    = 17,
  parameter int PER_N     = 32,
  parameter int CASC_CRIT = 2,
  parameter int CASC_MAIN = 4,
  parameter int DMA_SLOT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRIT_N-1:0] crit_src_i,
  input  logic [MAIN_N-1:0] main_src_i,
  input  logic [PER_N-1:0]  per_src_i,
  input  logic              dma_pend_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       status_o,
  output logic              irq_o
);
  localparam int CRIT_IW = $clog2(CRIT_N);
  localparam int MAIN_IW = $clog2(MAIN_N);
  localparam int PER_IW  = $clog2(PER_N);

  logic [MAIN_N-1:0]  main_mask;
  logic [PER_N-1:0]   per_mask;
  logic [CRIT_N-1:0]  crit_req;
  logic [MAIN_N-1:0]  main_req;
  logic [PER_N-1:0]   per_req;
  logic               crit_pres, main_pres, per_pres;
  logic [CRIT_IW-1:0] crit_idx;
  logic [MAIN_IW-1:0] main_idx;
  logic [PER_IW-1:0]  per_idx;
  logic [STAT_W-1:0]  status_d;
  logic               any_pres;

  irq_mask_regs #(.MAIN_N(MAIN_N), .PER_N(PER_N), .DW(32)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .main_mask_o(main_mask), .per_mask_o(per_mask)
  );

  // cascade slots replace the external lines at those positions
  always_comb begin
    per_req           = per_src_i;
    per_req[DMA_SLOT] = dma_pend_i;
    crit_req            = crit_src_i;
    crit_req[CASC_CRIT] = per_pres;
    main_req            = main_src_i;
    main_req[CASC_MAIN] = per_pres;
  end

  irq_group_enc #(.N(PER_N), .IW(PER_IW)) u_per (
    .clk(clk), .rst_n(rst_n), .req_i(per_req), .mask_i(per_mask),
    .present_o(per_pres), .idx_o(per_idx)
  );
  irq_group_enc #(.N(CRIT_N), .IW(CRIT_IW)) u_crit (
    .clk(clk), .rst_n(rst_n), .req_i(crit_req), .mask_i('0),
    .present_o(crit_pres), .idx_o(crit_idx)
  );
  irq_group_enc #(.N(MAIN_N), .IW(MAIN_IW)) u_main (
    .clk(clk), .rst_n(rst_n), .req_i(main_req), .mask_i(main_mask),
    .present_o(main_pres), .idx_o(main_idx)
  );

  always_comb begin
    status_d = '0;
    status_d[CRIT_PRES_BIT]              = crit_pres;
    status_d[CRIT_IDX_LSB +: CRIT_IW]    = crit_idx;
    status_d[MAIN_PRES_BIT]              = main_pres;
    status_d[MAIN_IDX_LSB +: MAIN_IW]    = main_idx;
    status_d[PER_PRES_BIT]               = per_pres;
    status_d[PER_IDX_LSB +: PER_IW]      = per_idx;
  end

  assign any_pres = crit_pres | main_pres | per_pres;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= status_d;
      irq_o    <= any_pres;
    end
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    any_pres |=> irq_o); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (status_o == '0)); // R8
  AST_CRIT_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    per_pres |=> (status_o[CRIT_PRES_BIT] &&
                  status_o[CRIT_IDX_LSB +: CRIT_IW] <= CRIT_IW'(CASC_CRIT))); // R6
  AST_DMA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_pend_i && !per_mask[DMA_SLOT]) |=>
      (status_o[PER_PRES_BIT] && status_o[PER_IDX_LSB +: PER_IW] == '0)); // R7
endmodule

// File: tb/test_irq_cascade_encoder.sv
module test_irq_cascade_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  crit_src = '0;
  logic [16:0] main_src = '0;
  logic [31:0] per_src = '0;
  logic        dma = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit model_on = 0;

  // reference state: masks kept in write-data bit order
  logic [16:0] m_main;
  logic [31:0] m_per;
  logic [31:0] exp_status;
  logic        exp_irq;

  always #2 clk = ~clk;

  irq_cascade_encoder i_irq_cascade_encoder (
    .clk(clk), .rst_n(rst_n), .crit_src_i(crit_src), .main_src_i(main_src),
    .per_src_i(per_src), .dma_pend_i(dma), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .status_o(status), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    int pw, cw, mw;
    bit line;
    if (!rst_n) begin
      m_main = '1; m_per = '1; exp_status = '0; exp_irq = 1'b0;
    end else begin
      pw = -1;
      for (int i = 31; i >= 0; i--) begin
        line = (i == 0) ? dma : per_src[i];
        if (line && !m_per[31 - i]) pw = i;
      end
      cw = -1;
      for (int i = 3; i >= 0; i--) begin
        line = (i == 2) ? (pw >= 0) : crit_src[i];
        if (line) cw = i;
      end
      mw = -1;
      for (int i = 16; i >= 0; i--) begin
        line = (i == 4) ? (pw >= 0) : main_src[i];
        if (line && !m_main[16 - i]) mw = i;
      end
      exp_status = 32'h0;
      if (cw >= 0) exp_status = exp_status | 32'h400 | (32'(cw) << 8);
      if (mw >= 0) exp_status = exp_status | 32'h200000 | (32'(mw) << 16);
      if (pw >= 0) exp_status = exp_status | 32'h20000000 | (32'(pw) << 24);
      exp_irq = (cw >= 0) || (mw >= 0) || (pw >= 0);
      if (wr_en && !wr_sel) m_main = wr_data[16:0];
      if (wr_en &&  wr_sel) m_per  = wr_data;
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (model_on && rst_n && !done) begin
      checks++;
      if (status !== exp_status || irq !== exp_irq) begin
        fails++;
        $display("FAIL R9 R3 R4 R5 model: status=%h irq=%b expected status=%h irq=%b",
                 status, irq, exp_status, exp_irq);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_mask(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1;
    @(negedge clk);
    chk("R1 reset status", status, 32'h0);
    chk("R1 reset irq", 32'(irq), 32'h0);

    crit_src = 4'b1010; settle();
    chk("R3 crit lowest", status, 32'h00000500);
    crit_src = 4'b0100; settle();
    chk("R6 crit slot2 external ignored", status, 32'h0);
    crit_src = 4'b0000;

    main_src = 17'h00088; settle();
    chk("R1 main masked after reset", status, 32'h0);
    wr_mask(1'b0, 32'h0); settle();
    chk("R4 main lowest", status, 32'h00230000);
    wr_mask(1'b0, 32'h00002000); settle();
    chk("R2 main bit 16-n masks n", status, 32'h00270000);
    main_src = 17'h00010; settle();
    chk("R6 main slot4 external ignored", status, 32'h0);
    main_src = '0;

    wr_mask(1'b1, 32'h0);
    per_src = 32'h20; settle();
    chk("R5 R6 peripheral with cascades", status, 32'h25240600);
    per_src = 32'h0; dma = 1'b1; settle();
    chk("R7 dma slot", status, 32'h20240600);
    dma = 1'b0; per_src = 32'h1; settle();
    chk("R7 per_src bit0 ignored", status, 32'h0);
    per_src = '0;

    wr_mask(1'b0, 32'h00010fff);
    wr_mask(1'b1, 32'h7ffffc00);
    per_src = 32'h02000000; settle();
    chk("R2 typical masks pass source 25", status, 32'h39240600);
    per_src = 32'h00000400; settle();
    chk("R2 typical masks block source 10", status, 32'h0);
    chk("R8 idle irq", 32'(irq), 32'h0);
    per_src = '0;

    @(negedge clk);
    crit_src = 4'b0001;
    #1;
    chk("R9 irq not before edge", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R9 irq one edge later", 32'(irq), 32'h1);
    chk("R8 R3 crit idx0 only", status, 32'h00000400);
    crit_src = '0;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk("R9 irq drops", 32'(irq), 32'h0);
    finish_run();
  end
endmodule